// File: doc/BRIEF.md
# Mapping Command Field Decoder

This block sits behind a command queue consumer and takes over whenever the consumer meets a device-mapping or collection-mapping command. The consumer hands it the opcode, the byte address of the 32-byte queue entry and the entry's first doubleword. The block then reads the remaining operand doublewords it needs through a simple memory-read master port. It pulls the operands out of those words and checks them against limits supplied as configuration inputs. If the command is in range, it emits a single table-update request carrying the decoded operands.

Out-of-range commands are dropped without a table update, but they still complete as a success so that the queue moves on past them. A bus error on any operand read stops the command at once and completes it as a failure, so that the consumer can stall. Writing the table entries is left to whatever consumes the update request.

Top module: `map_cmd_decoder`

## Requirements
- R1: After reset, busy, rd_req_valid, done, fail and upd_valid are all 0.
- R2: For opcode 0x08 (device mapping), the block reads entry address +8 and then +16. Each read is a one-cycle rd_req_valid pulse. The first pulse comes in the cycle after start is accepted, and the second in the cycle after the first read's response. No read is issued while a response is outstanding.
- R3: For opcode 0x09 (collection mapping), the block reads only entry address +16, in the cycle after start is accepted.
- R4: A device-mapping update carries the following fields:
  - upd_is_dev = 1
  - upd_index = doubleword 0 bits 63:32
  - upd_size = doubleword 1 bits 4:0
  - upd_taddr = doubleword 2 bits 51:8
  - upd_live = doubleword 2 bit 63
  - upd_target = 0
- R5: A collection-mapping update carries the following fields. Bits 47:32 of doubleword 2 have no effect.
  - upd_is_dev = 0
  - upd_index = doubleword 2 bits 15:0
  - upd_target = doubleword 2 bits 31:16
  - upd_live = doubleword 2 bit 63
  - upd_size = 0
  - upd_taddr = 0
- R6: A device-mapping command whose device ID exceeds max_dev_id, or whose size exceeds id_bits_limit, completes with done=1 and fail=0 and no upd_valid. Values equal to the limit are accepted.
- R7: A collection-mapping command whose collection ID exceeds max_coll_id, or whose target exceeds proc_count, completes with done=1 and fail=0 and no upd_valid. Values equal to the limit are accepted.
- R8: A read response with rd_rsp_err=1 ends the command. In the next cycle done=1 and fail=1, with no further read and no upd_valid.
- R9: Any other opcode completes with a one-cycle done pulse (fail=0) in the cycle after start, with no read.
- R10: A successful command raises done (and upd_valid, when not dropped) for exactly one cycle, in the cycle after the last response. start_valid is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Command hand-over strobe, taken when not busy |
| start_opcode | input | 8 | Command opcode |
| start_addr | input | ADDR_W | Byte address of the queue entry |
| start_dw0 | input | 64 | First doubleword of the entry |
| busy | output | 1 | Command in progress |
| rd_req_valid | output | 1 | Operand read request pulse |
| rd_req_addr | output | ADDR_W | Operand read byte address |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | 64 | Read response data |
| rd_rsp_err | input | 1 | Read response bus error |
| max_dev_id | input | 32 | Largest accepted device ID |
| id_bits_limit | input | 5 | Largest accepted size field |
| max_coll_id | input | 16 | Largest accepted collection ID |
| proc_count | input | 16 | Largest accepted target value |
| done | output | 1 | Command complete pulse |
| fail | output | 1 | Completion was a bus failure |
| upd_valid | output | 1 | Table-update request pulse |
| upd_is_dev | output | 1 | 1 = device table, 0 = collection table |
| upd_index | output | 32 | Device or collection ID |
| upd_live | output | 1 | Entry valid flag |
| upd_size | output | 5 | Device size field |
| upd_taddr | output | 44 | Translation-table address, shifted down by 8 |
| upd_target | output | 16 | Collection target |

## Verification
The stimulus covers several cases:
- Device-mapping commands with zero and several cycles of read latency, which separate the two-read ordering from a wrong offset or an early second request.
- Stray bits set around every field, which expose wrong slicing.
- Values placed exactly at each limit and one above it, which separate a strict comparison from an inclusive one on each of the four checks.
- A bus error injected on each possible read.
- Foreign opcodes, including a second start held high throughout every busy period, which distinguish a clean ignore from a restart.

// File: rtl/map_cmd_decoder.sv
module map_cmd_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [7:0]        start_opcode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [63:0]       start_dw0,
  output logic              busy,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  input  logic [31:0]       max_dev_id,
  input  logic [4:0]        id_bits_limit,
  input  logic [15:0]       max_coll_id,
  input  logic [15:0]       proc_count,
  output logic              done,
  output logic              fail,
  output logic              upd_valid,
  output logic              upd_is_dev,
  output logic [31:0]       upd_index,
  output logic              upd_live,
  output logic [4:0]        upd_size,
  output logic [43:0]       upd_taddr,
  output logic [15:0]       upd_target
);

  localparam logic [7:0] OP_DEV  = 8'h08;
  localparam logic [7:0] OP_COLL = 8'h09;
  localparam logic [ADDR_W-1:0] OFS1 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS2 = ADDR_W'(16);

  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic              is_dev_q;
  logic [31:0]       dev_q;
  logic [4:0]        size_q;

  logic [15:0] coll_w;
  logic [15:0] tgt_w;
  logic [43:0] taddr_w;
  logic        live_w;
  logic        drop_w;
  logic        unused_bits;

  assign busy         = (st != S_IDLE);
  assign rd_req_valid = (st == S_REQ1) || (st == S_REQ2);
  assign rd_req_addr  = base_q + ((st == S_REQ1) ? OFS1 : OFS2);

  assign coll_w  = rd_rsp_data[15:0];
  assign tgt_w   = rd_rsp_data[31:16];
  assign taddr_w = rd_rsp_data[51:8];
  assign live_w  = rd_rsp_data[63];
  assign drop_w  = is_dev_q ? ((dev_q > max_dev_id) || (size_q > id_bits_limit))
                            : ((coll_w > max_coll_id) || (tgt_w > proc_count));
  assign unused_bits = ^{rd_rsp_data[62:52], start_dw0[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      is_dev_q   <= 1'b0;
      dev_q      <= '0;
      size_q     <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      upd_valid  <= 1'b0;
      upd_is_dev <= 1'b0;
      upd_index  <= '0;
      upd_live   <= 1'b0;
      upd_size   <= '0;
      upd_taddr  <= '0;
      upd_target <= '0;
    end else begin
      done      <= 1'b0;
      fail      <= 1'b0;
      upd_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (start_valid) begin
          base_q   <= start_addr;
          dev_q    <= start_dw0[63:32];
          is_dev_q <= (start_opcode == OP_DEV);
          if (start_opcode == OP_DEV)       st   <= S_REQ1;
          else if (start_opcode == OP_COLL) st   <= S_REQ2;
          else                              done <= 1'b1;
        end
        S_REQ1: st <= S_WAIT1;
        S_REQ2: st <= S_WAIT2;
        S_WAIT1: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            st   <= S_IDLE;
            done <= 1'b1;
            fail <= 1'b1;
          end else begin
            size_q <= rd_rsp_data[4:0];
            st     <= S_REQ2;
          end
        end
        S_WAIT2: if (rd_rsp_valid) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (rd_rsp_err) begin
            fail <= 1'b1;
          end else if (!drop_w) begin
            upd_valid  <= 1'b1;
            upd_is_dev <= is_dev_q;
            upd_index  <= is_dev_q ? dev_q : {16'b0, coll_w};
            upd_live   <= live_w;
            upd_size   <= is_dev_q ? size_q : 5'd0;
            upd_taddr  <= is_dev_q ? taddr_w : 44'd0;
            upd_target <= is_dev_q ? 16'd0 : tgt_w;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/map_cmd_decoder_chk.sv
module map_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req_valid,
  input logic        rd_rsp_valid,
  input logic        rd_rsp_err,
  input logic        done,
  input logic        fail,
  input logic        upd_valid,
  input logic        upd_is_dev,
  input logic [31:0] upd_index,
  input logic [4:0]  upd_size,
  input logic [15:0] upd_target,
  input logic [31:0] max_dev_id,
  input logic [4:0]  id_bits_limit,
  input logic [15:0] max_coll_id,
  input logic [15:0] proc_count
);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> !rd_req_valid);

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);

  assert_upd_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (done && !fail));

  assert_fail_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  assert_err_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_req_valid && rd_rsp_valid && rd_rsp_err) |=> (done && fail && !upd_valid));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && $past(busy)) |=> !done);

  assert_dev_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_dev) |-> ((upd_index <= max_dev_id) && (upd_size <= id_bits_limit)));

  assert_coll_limits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_dev) |-> ((upd_index <= {16'b0, max_coll_id}) && (upd_target <= proc_count)));

endmodule

bind map_cmd_decoder map_cmd_decoder_chk u_chk (.*);

// File: tb/map_cmd_decoder_test.sv
`timescale 1ns/1ps
module map_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [7:0]  start_opcode = '0;
  logic [31:0] start_addr = '0;
  logic [63:0] start_dw0 = '0;
  logic        busy, rd_req_valid;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic [31:0] max_dev_id = 32'd100;
  logic [4:0]  id_bits_limit = 5'd16;
  logic [15:0] max_coll_id = 16'd31;
  logic [15:0] proc_count = 16'd4;
  logic        done, fail, upd_valid, upd_is_dev, upd_live;
  logic [31:0] upd_index;
  logic [4:0]  upd_size;
  logic [43:0] upd_taddr;
  logic [15:0] upd_target;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;
  logic [98:0] exp_fields;

  always #2 clk = ~clk;

  map_cmd_decoder #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_opcode(start_opcode),
    .start_addr(start_addr), .start_dw0(start_dw0), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .max_dev_id(max_dev_id), .id_bits_limit(id_bits_limit), .max_coll_id(max_coll_id),
    .proc_count(proc_count), .done(done), .fail(fail), .upd_valid(upd_valid),
    .upd_is_dev(upd_is_dev), .upd_index(upd_index), .upd_live(upd_live),
    .upd_size(upd_size), .upd_taddr(upd_taddr), .upd_target(upd_target));

  task automatic cmp(string tag, bit eb, bit er, logic [31:0] ea, bit ed, bit ef, bit eu);
    logic [4:0] act = {busy, rd_req_valid, done, fail, upd_valid};
    logic [4:0] exp = {eb, er, ed, ef, eu};
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s ctrl {busy,req,done,fail,upd} act=%b exp=%b", tag, act, exp);
    end else if (er && rd_req_addr !== ea) begin
      nbad++;
      $display("FAIL %s rd_req_addr act=%h exp=%h", tag, rd_req_addr, ea);
    end else if (eu && {upd_is_dev, upd_index, upd_live, upd_size, upd_taddr, upd_target} !== exp_fields) begin
      nbad++;
      $display("FAIL %s fields act=%h exp=%h", tag,
               {upd_is_dev, upd_index, upd_live, upd_size, upd_taddr, upd_target}, exp_fields);
    end
  endtask

  task automatic phase(string tag, logic [31:0] addr, logic [63:0] data, int lat, bit err, bit last);
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    cmp(tag, 1, 1, addr, 0, 0, 0);
    for (int i = 0; i <= lat; i++) begin
      @(negedge clk);
      cmp(tag, 1, 0, '0, 0, 0, 0);
    end
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = data;
    rd_rsp_err   = err;
    if (last || err) start_valid = 1'b0;
  endtask

  task automatic run_cmd(string tag, logic [7:0] op, logic [31:0] addr,
                         logic [63:0] dw0, logic [63:0] dw1, logic [63:0] dw2,
                         int lat, int err_at);
    bit is_dev = (op == 8'h08);
    bit is_map = (op == 8'h08) || (op == 8'h09);
    longint unsigned dev = dw0 >> 32;
    int size = int'(dw1 & 64'h1f);
    longint unsigned taddr = (dw2 >> 8) & ((64'd1 << 44) - 1);
    int coll = int'(dw2 & 64'hffff);
    int tgt = int'((dw2 >> 16) & 64'hffff);
    bit live = dw2[63];
    bit drop;
    if (is_dev) begin
      drop = (dev > longint'(max_dev_id)) || (size > int'(id_bits_limit));
      exp_fields = {1'b1, dev[31:0], live, size[4:0], taddr[43:0], 16'd0};
    end else begin
      drop = (coll > int'(max_coll_id)) || (tgt > int'(proc_count));
      exp_fields = {1'b0, 16'd0, coll[15:0], live, 5'd0, 44'd0, tgt[15:0]};
    end
    @(negedge clk);
    cmp({tag, " idle"}, 0, 0, '0, 0, 0, 0);
    start_valid = 1'b1; start_opcode = op; start_addr = addr; start_dw0 = dw0;
    if (!is_map) begin
      @(negedge clk);
      start_valid = 1'b0;
      cmp(tag, 0, 0, '0, 1, 0, 0);
    end else begin
      @(negedge clk);
      start_opcode = 8'h05;
      start_dw0 = ~dw0;
      #0;
      if (is_dev) begin
        rd_rsp_valid = 1'b0;
        cmp(tag, 1, 1, addr + 8, 0, 0, 0);
        for (int i = 0; i <= lat; i++) begin
          @(negedge clk);
          cmp(tag, 1, 0, '0, 0, 0, 0);
        end
        rd_rsp_valid = 1'b1; rd_rsp_data = dw1; rd_rsp_err = (err_at == 1);
        if (err_at == 1) start_valid = 1'b0;
        if (err_at != 1) phase(tag, addr + 16, dw2, lat, err_at == 2, 1);
      end else begin
        rd_rsp_valid = 1'b0;
        cmp(tag, 1, 1, addr + 16, 0, 0, 0);
        for (int i = 0; i <= lat; i++) begin
          @(negedge clk);
          cmp(tag, 1, 0, '0, 0, 0, 0);
        end
        rd_rsp_valid = 1'b1; rd_rsp_data = dw2; rd_rsp_err = (err_at == 2);
        start_valid = 1'b0;
      end
      @(negedge clk);
      rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
      if (err_at != 0) cmp(tag, 0, 0, '0, 1, 1, 0);
      else             cmp(tag, 0, 0, '0, 1, 0, !drop);
    end
    @(negedge clk);
    cmp({tag, " after"}, 0, 0, '0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    exp_fields = '0;
    repeat (3) @(negedge clk);
    cmp("R1 reset", 0, 0, '0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 post reset", 0, 0, '0, 0, 0, 0);

    run_cmd("R2 R4 dev basic", 8'h08, 32'h1000,
            {32'd7, 32'hdead_beef}, 64'hffff_fff0_0000_000a,
            {1'b1, 11'h7ff, 44'hABC_DEF1_2345, 8'hff}, 0, 0);
    run_cmd("R2 R4 dev slow", 8'h08, 32'h2040,
            {32'd55, 32'h1}, 64'h0000_0001_0000_0003,
            {1'b0, 11'h155, 44'h123_4567_89AB, 8'h5a}, 3, 0);
    run_cmd("R6 dev id at limit", 8'h08, 32'h80, {32'd100, 32'h0}, 64'd16,
            {1'b1, 11'h0, 44'h1, 8'h0}, 1, 0);
    run_cmd("R6 dev id over", 8'h08, 32'h80, {32'd101, 32'h0}, 64'd3,
            {1'b1, 11'h0, 44'h1, 8'h0}, 0, 0);
    run_cmd("R6 size over", 8'h08, 32'h80, {32'd3, 32'h0}, 64'd17,
            {1'b1, 11'h0, 44'h1, 8'h0}, 2, 0);
    run_cmd("R3 R5 coll basic", 8'h09, 32'h3000, 64'hffff_ffff_ffff_ff09,
            64'hffff_ffff_ffff_ffff, {1'b1, 15'h0, 16'hbeef, 16'd3, 16'd5}, 0, 0);
    run_cmd("R5 coll slow live0", 8'h09, 32'h3020, 64'h9,
            64'h0, {1'b0, 15'h7fff, 16'h0001, 16'd2, 16'd17}, 4, 0);
    run_cmd("R7 coll at limit", 8'h09, 32'h40, 64'h9, 64'h0,
            {1'b1, 15'h0, 16'h0, 16'd4, 16'd31}, 0, 0);
    run_cmd("R7 coll id over", 8'h09, 32'h40, 64'h9, 64'h0,
            {1'b1, 15'h0, 16'h0, 16'd1, 16'd32}, 0, 0);
    run_cmd("R7 target over", 8'h09, 32'h40, 64'h9, 64'h0,
            {1'b1, 15'h0, 16'h0, 16'd5, 16'd2}, 1, 0);
    run_cmd("R8 dev err first", 8'h08, 32'h500, {32'd1, 32'h0}, 64'd1, 64'h0, 0, 1);
    run_cmd("R8 dev err second", 8'h08, 32'h520, {32'd1, 32'h0}, 64'd1,
            {1'b1, 63'h0}, 2, 2);
    run_cmd("R8 coll err", 8'h09, 32'h540, 64'h9, 64'h0, {1'b1, 63'h3}, 1, 2);
    run_cmd("R9 other op 05", 8'h05, 32'h600, 64'h5, 64'h0, 64'h0, 0, 0);
    run_cmd("R9 other op 03", 8'h03, 32'h620, 64'h3, 64'h0, 64'h0, 0, 0);
    run_cmd("R10 dev after others", 8'h08, 32'h700, {32'd9, 32'h8}, 64'd4,
            {1'b1, 11'h0, 44'hFFF_FFFF_FFFF, 8'h1}, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule